// File: doc/BRIEF.md
# Real-Time Clock Byte Register File

This block is the byte-wide storage and command decoder behind the serial port of a real-time clock. A serial front end outside this block shifts bytes in and out. For each byte it passes on, it gives a one-cycle strobe, and it holds a transaction-active flag for the whole exchange. The first byte of each transaction is a command. The block decodes it into one of these accesses:

- a single-register access to a clock register,
- a single-register access to the control register,
- a single-register access to one scratch-RAM byte,
- a burst over all clock registers and the control register,
- a burst over the whole scratch RAM.

The block holds seven clock/calendar bytes, a control byte whose top bit is a write-protect flag, and 31 bytes of scratch RAM. The write-protect flag is checked on every write. Clock bursts are staged in a shadow buffer, and the clock registers update only when a complete burst has arrived. RAM bursts update each byte as soon as it arrives. Read data is registered, and a new byte is shown after every strobe so that the front end can shift it out.

The hours byte carries the display-mode bit and the AM/PM bit. These two flags are decoded and brought out as outputs. Counting time, the oscillator and battery charging are all handled elsewhere.

Top module: `rtcRegFile`

## Requirements
- R1: Control bit 7 is the write-protect flag. Control bits 6..0 always read as 0, whatever value was written to them. The control register can be written even while write-protect is 1.
- R2: While write-protect is 1, writes to clock registers and to RAM bytes have no effect, for both single and burst commands.
- R3: Command byte layout:
  - Bit 7 must be 1 for the command to be valid.
  - Bit 0 selects read when 1 and write when 0.
  - Bit 6 selects RAM when 1 and the clock space when 0.
  - Bits 5..1 are the index.
  - In the clock space, index 0..6 selects a clock byte, in the order seconds, minutes, hours, date, month, weekday, year (commands 80h..8Dh). Index 7 selects the control register (8Eh write, 8Fh read).
  - In the RAM space, index 0..30 selects a RAM byte (C0h..FDh).
  - A command with bit 7 = 0, or a clock-space index from 8 to 30, writes nothing and reads 00h.
- R4: Command BEh writes and BFh reads a clock burst. The burst covers the seven clock bytes in index order and then the control byte.
- R5: A clock burst write changes no register unless all eight bytes arrive. If the transaction ends early, all eight registers keep their old values.
- R6: If write-protect is 1 when a clock burst write command is taken, neither the clock bytes nor the control register change.
- R7: Command FEh writes and FFh reads a RAM burst over bytes 0..30 in order. Each written byte is stored as soon as it arrives, so a partial burst still updates the bytes that were sent.
- R8: A single-register command covers one byte position. Once a command's last position has been used, further written bytes are ignored and further read bytes are 00h.
- R9: Hours bit 7 = 1 selects 12-hour mode, reported on `hour12Mode`. `hourPm` is 1 only in 12-hour mode with hours bit 5 = 1. In 24-hour mode, bit 5 is a tens-of-hours bit and `hourPm` stays 0.
- R10: After reset, write-protect is 1 and every clock and RAM byte reads 00h.
- R11: `rdData` is registered. After the strobe that carries a read command, it shows the first addressed byte. After each later strobe in that transaction, it shows the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txnActive | input | 1 | High for the whole transaction; low returns the block to waiting for a command |
| byteValid | input | 1 | One-cycle strobe: a byte has been shifted in (or out) |
| byteIn | input | 8 | Command or data byte, valid with `byteValid` |
| rdData | output | 8 | Byte the front end shifts out next |
| hour12Mode | output | 1 | 1 when the hours byte selects 12-hour mode |
| hourPm | output | 1 | PM flag, valid in 12-hour mode |

## Verification
Every result of this block appears one clock edge after the strobe that causes it:

- `rdData` holds the addressed byte after the edge that takes a read command or data strobe.
- The storage and the hour flags change on the edge of the write strobe.
- A clock burst commits on the edge of its eighth strobe.

The bench drives each strobe for one full cycle from the falling edge. It samples at the next falling edge, which is half a cycle after the edge that produced the value. Writes are confirmed only through later read transactions at the ports, so a write that should have been ignored is seen as an unchanged read value.

// File: rtl/rtcRegPkg.sv
package rtcRegPkg;

  // Width of the index field carried in a command byte (bits 5..1).
  localparam int IDX_W = 5;

  typedef enum logic [1:0] {
    SP_NONE,
    SP_CLK,
    SP_CTL,
    SP_RAM
  } space_e;

  typedef enum logic [2:0] {
    MODE_NONE,
    MODE_CLK_SINGLE,
    MODE_CTL_SINGLE,
    MODE_RAM_SINGLE,
    MODE_CLK_BURST,
    MODE_RAM_BURST
  } mode_e;

  typedef enum logic {
    PH_CMD,
    PH_DATA
  } phase_e;

  // Strobes from control to datapath, all valid for one cycle.
  typedef struct packed {
    logic             wrClk;     // single clock-byte write
    logic             wrCtl;     // control-byte write
    logic             wrRam;     // RAM-byte write (single or burst)
    logic             stageClk;  // clock burst byte into shadow
    logic             commitClk; // eighth burst byte: copy shadow, write control
    logic             loadRd;    // load read register
    space_e           rdSpace;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
  } strobe_t;

endpackage

// File: rtl/rtcRegCtrl.sv
module rtcRegCtrl
  import rtcRegPkg::*;
#(
  parameter int CLK_REGS  = 7,
  parameter int RAM_BYTES = 31
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txnActive,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  input  logic       wpBit,
  output strobe_t    str
);

  localparam int PW = IDX_W + 1;
  localparam logic [IDX_W-1:0] BURST_CODE = '1;
  localparam logic [PW-1:0] CTL_POS = PW'(CLK_REGS);
  localparam logic [PW-1:0] CLK_LEN = PW'(CLK_REGS + 1);
  localparam logic [PW-1:0] RAM_LEN = PW'(RAM_BYTES);

  phase_e          phaseQ;
  mode_e           modeQ;
  logic            readQ;
  logic            blockedQ;
  logic [PW-1:0]   ptrQ;
  logic [PW-1:0]   endQ;

  // ---------------- command decode ----------------
  logic [IDX_W-1:0] cmdIdx;
  mode_e            decMode;
  logic [PW-1:0]    decBase;
  logic [PW-1:0]    decEnd;

  always_comb begin
    cmdIdx  = byteIn[5:1];
    decMode = MODE_NONE;
    decBase = '0;
    decEnd  = '0;
    if (byteIn[7]) begin
      if (byteIn[6]) begin
        if (cmdIdx == BURST_CODE) begin
          decMode = MODE_RAM_BURST;
          decEnd  = RAM_LEN;
        end else if (PW'(cmdIdx) < RAM_LEN) begin
          decMode = MODE_RAM_SINGLE;
          decBase = PW'(cmdIdx);
          decEnd  = PW'(cmdIdx) + PW'(1);
        end
      end else begin
        if (cmdIdx == BURST_CODE) begin
          decMode = MODE_CLK_BURST;
          decEnd  = CLK_LEN;
        end else if (PW'(cmdIdx) < CTL_POS) begin
          decMode = MODE_CLK_SINGLE;
          decBase = PW'(cmdIdx);
          decEnd  = PW'(cmdIdx) + PW'(1);
        end else if (PW'(cmdIdx) == CTL_POS) begin
          decMode = MODE_CTL_SINGLE;
          decBase = CTL_POS;
          decEnd  = CLK_LEN;
        end
      end
    end
  end

  function automatic space_e spaceAt(mode_e m, logic [PW-1:0] p, logic [PW-1:0] e);
    if (p >= e) return SP_NONE;
    case (m)
      MODE_CLK_SINGLE: return SP_CLK;
      MODE_CTL_SINGLE: return SP_CTL;
      MODE_RAM_SINGLE,
      MODE_RAM_BURST:  return SP_RAM;
      MODE_CLK_BURST:  return (p == CTL_POS) ? SP_CTL : SP_CLK;
      default:         return SP_NONE;
    endcase
  endfunction

  // ---------------- strobe generation ----------------
  logic [PW-1:0] nextPos;
  logic          stepOk;

  assign nextPos = ptrQ + PW'(1);
  assign stepOk  = ptrQ < endQ;

  always_comb begin
    str = '0;
    if (txnActive && byteValid) begin
      if (phaseQ == PH_CMD) begin
        if (byteIn[0]) begin
          str.loadRd  = 1'b1;
          str.rdSpace = spaceAt(decMode, decBase, decEnd);
          str.rdIdx   = decBase[IDX_W-1:0];
        end
      end else if (readQ) begin
        str.loadRd  = 1'b1;
        str.rdSpace = spaceAt(modeQ, nextPos, endQ);
        str.rdIdx   = nextPos[IDX_W-1:0];
      end else if (stepOk) begin
        str.wrIdx = ptrQ[IDX_W-1:0];
        case (modeQ)
          MODE_CLK_SINGLE: str.wrClk = !wpBit;
          MODE_CTL_SINGLE: str.wrCtl = 1'b1;
          MODE_RAM_SINGLE,
          MODE_RAM_BURST:  str.wrRam = !wpBit;
          MODE_CLK_BURST: begin
            if (!blockedQ) begin
              if (ptrQ == CTL_POS) str.commitClk = 1'b1;
              else                 str.stageClk  = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- transaction state ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ   <= PH_CMD;
      modeQ    <= MODE_NONE;
      readQ    <= 1'b0;
      blockedQ <= 1'b0;
      ptrQ     <= '0;
      endQ     <= '0;
    end else if (!txnActive) begin
      phaseQ <= PH_CMD;
    end else if (byteValid) begin
      if (phaseQ == PH_CMD) begin
        phaseQ   <= PH_DATA;
        modeQ    <= decMode;
        readQ    <= byteIn[0];
        ptrQ     <= decBase;
        endQ     <= decEnd;
        blockedQ <= wpBit;
      end else if (stepOk) begin
        ptrQ <= nextPos;
      end
    end
  end

  // ---------------- checks ----------------
  logic [PW-1:0] stageCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                                             stageCnt <= '0;
    else if (txnActive && byteValid && phaseQ == PH_CMD)   stageCnt <= '0;
    else if (str.stageClk)                                 stageCnt <= stageCnt + PW'(1);
  end

  // R5: commit only after the seven clock bytes were staged in this burst
  p_commit_full_burst_r5: assert property (@(posedge clk) disable iff (!rstN)
    str.commitClk |-> (stageCnt == CTL_POS));

  // R6: a commit never happens while write-protect is set
  p_commit_unprotected_r6: assert property (@(posedge clk) disable iff (!rstN)
    str.commitClk |-> !wpBit);

  // R8: the position pointer never runs past the end of its command
  p_ptr_within_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_DATA) |-> (ptrQ <= endQ));

  // R3: at most one kind of write per strobe
  p_write_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.wrClk, str.wrCtl, str.wrRam, str.stageClk, str.commitClk}));

endmodule

// File: rtl/rtcRegDatapath.sv
module rtcRegDatapath
  import rtcRegPkg::*;
#(
  parameter int CLK_REGS  = 7,
  parameter int RAM_BYTES = 31,
  parameter int HOUR_IDX  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    str,
  input  logic [7:0] byteIn,
  output logic       wpBit,
  output logic [7:0] rdData,
  output logic       hour12Mode,
  output logic       hourPm
);

  localparam int CLK_AW = $clog2(CLK_REGS);
  localparam int RAM_AW = $clog2(RAM_BYTES);

  logic [CLK_REGS-1:0][7:0]  clkRegs;
  logic [CLK_REGS-1:0][7:0]  shadow;
  logic [RAM_BYTES-1:0][7:0] ramMem;
  logic                      wpQ;
  logic [7:0]                rdQ;
  logic [7:0]                rdNext;

  // Clock bytes, shadow and control flag.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkRegs <= '0;
      shadow  <= '0;
      wpQ     <= 1'b1;
    end else begin
      if (str.wrClk)    clkRegs[str.wrIdx[CLK_AW-1:0]] <= byteIn;
      if (str.stageClk) shadow[str.wrIdx[CLK_AW-1:0]]  <= byteIn;
      if (str.wrCtl)    wpQ <= byteIn[7];
      if (str.commitClk) begin
        clkRegs <= shadow;
        wpQ     <= byteIn[7];
      end
    end
  end

  // Scratch RAM.
  always_ff @(posedge clk) begin
    if (!rstN)          ramMem <= '0;
    else if (str.wrRam) ramMem[str.wrIdx[RAM_AW-1:0]] <= byteIn;
  end

  // Read selection, registered toward the shift front end.
  always_comb begin
    case (str.rdSpace)
      SP_CLK:  rdNext = clkRegs[str.rdIdx[CLK_AW-1:0]];
      SP_CTL:  rdNext = {wpQ, 7'b0};
      SP_RAM:  rdNext = ramMem[str.rdIdx[RAM_AW-1:0]];
      default: rdNext = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdQ <= 8'h00;
    else if (str.loadRd) rdQ <= rdNext;
  end

  assign wpBit      = wpQ;
  assign rdData     = rdQ;
  assign hour12Mode = clkRegs[HOUR_IDX][7];
  assign hourPm     = clkRegs[HOUR_IDX][7] & clkRegs[HOUR_IDX][5];

  // R2: protected clock bytes hold unless only the control byte is written
  p_wp_freezes_clock_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wpQ && !str.wrCtl) |=> $stable(clkRegs));

  // R2: protected RAM holds
  p_wp_freezes_ram_r2: assert property (@(posedge clk) disable iff (!rstN)
    wpQ |=> $stable(ramMem));

  // R1: a read of the control byte never shows its low bits
  p_ctl_low_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (str.loadRd && str.rdSpace == SP_CTL) |=> (rdData[6:0] == 7'd0));

  // R5: a commit lands the staged bytes in the live registers
  p_commit_copies_r5: assert property (@(posedge clk) disable iff (!rstN)
    str.commitClk |=> (clkRegs == $past(shadow)));

endmodule

// File: rtl/rtcRegFile.sv
module rtcRegFile
  import rtcRegPkg::*;
#(
  parameter int CLK_REGS  = 7,
  parameter int RAM_BYTES = 31,
  parameter int HOUR_IDX  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txnActive,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  output logic [7:0] rdData,
  output logic       hour12Mode,
  output logic       hourPm
);

  strobe_t str;
  logic    wpBit;

  rtcRegCtrl #(
    .CLK_REGS (CLK_REGS),
    .RAM_BYTES(RAM_BYTES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .txnActive(txnActive),
    .byteValid(byteValid),
    .byteIn   (byteIn),
    .wpBit    (wpBit),
    .str      (str)
  );

  rtcRegDatapath #(
    .CLK_REGS (CLK_REGS),
    .RAM_BYTES(RAM_BYTES),
    .HOUR_IDX (HOUR_IDX)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .byteIn    (byteIn),
    .wpBit     (wpBit),
    .rdData    (rdData),
    .hour12Mode(hour12Mode),
    .hourPm    (hourPm)
  );

endmodule

// File: tb/rtcRegFile_tb.sv
module rtcRegFile_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txnActive = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic [7:0] rdData;
  logic       hour12Mode;
  logic       hourPm;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  logic [7:0] ramExp [31];

  rtcRegFile u_dut (
    .clk(clk), .rstN(rstN), .txnActive(txnActive), .byteValid(byteValid),
    .byteIn(byteIn), .rdData(rdData), .hour12Mode(hour12Mode), .hourPm(hourPm)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: act=%0d cycles exp<100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic beginTxn();
    @(negedge clk);
    txnActive = 1'b1;
  endtask

  task automatic endTxn();
    @(negedge clk);
    txnActive = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    byteIn    = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic writeReg(input logic [7:0] cmd, input logic [7:0] val);
    beginTxn();
    sendByte(cmd);
    sendByte(val);
    endTxn();
  endtask

  task automatic readReg(input logic [7:0] cmd, output logic [7:0] v);
    beginTxn();
    sendByte(cmd);
    v = rdData;
    endTxn();
  endtask

  task automatic testReset();
    logic [7:0] v;
    readReg(8'h8F, v); check("R10 control after reset", v, 8'h80);
    readReg(8'h81, v); check("R10 seconds after reset", v, 8'h00);
    readReg(8'hC1, v); check("R10 ram0 after reset", v, 8'h00);
    check("R10 hour12Mode after reset", {7'd0, hour12Mode}, 8'h00);
  endtask

  task automatic testWpBlocks();
    logic [7:0] v;
    writeReg(8'h80, 8'h45);
    writeReg(8'hC0, 8'h77);
    readReg(8'h81, v); check("R2 protected clock write", v, 8'h00);
    readReg(8'hC1, v); check("R2 protected ram write", v, 8'h00);
  endtask

  task automatic testControl();
    logic [7:0] v;
    writeReg(8'h8E, 8'h7F);
    readReg(8'h8F, v); check("R1 low bits cleared", v, 8'h00);
    writeReg(8'h8E, 8'hFF);
    readReg(8'h8F, v); check("R1 wp set, low bits zero", v, 8'h80);
    writeReg(8'h8E, 8'h00);
    readReg(8'h8F, v); check("R1 wp cleared", v, 8'h00);
  endtask

  task automatic testSingle();
    logic [7:0] v;
    writeReg(8'h80, 8'h59);
    readReg(8'h81, v); check("R3 seconds", v, 8'h59);
    writeReg(8'h8C, 8'h24);
    readReg(8'h8D, v); check("R3 year", v, 8'h24);
    writeReg(8'hFC, 8'hA5); ramExp[30] = 8'hA5;
    readReg(8'hFD, v); check("R3 ram30", v, 8'hA5);
    writeReg(8'hCA, 8'h3C); ramExp[5] = 8'h3C;
    readReg(8'hCB, v); check("R3 ram5", v, 8'h3C);
    writeReg(8'h00, 8'h11);
    readReg(8'h81, v); check("R3 bit7-clear command ignored", v, 8'h59);
    readReg(8'h01, v); check("R3 bit7-clear read", v, 8'h00);
    readReg(8'h91, v); check("R3 unused clock index read", v, 8'h00);
  endtask

  task automatic testSingleExtra();
    logic [7:0] v;
    beginTxn();
    sendByte(8'h80); sendByte(8'h12); sendByte(8'h34);
    endTxn();
    beginTxn();
    sendByte(8'h81); check("R8 single write keeps first byte", rdData, 8'h12);
    sendByte(8'h00); check("R8 single read extra byte", rdData, 8'h00);
    endTxn();
    readReg(8'h83, v); check("R8 neighbour untouched", v, 8'h00);
  endtask

  task automatic testHours();
    writeReg(8'h84, 8'h92);
    check("R9 12h AM mode", {7'd0, hour12Mode}, 8'h01);
    check("R9 12h AM pm", {7'd0, hourPm}, 8'h00);
    writeReg(8'h84, 8'hB1);
    check("R9 12h PM pm", {7'd0, hourPm}, 8'h01);
    writeReg(8'h84, 8'h23);
    check("R9 24h mode", {7'd0, hour12Mode}, 8'h00);
    check("R9 24h bit5 not pm", {7'd0, hourPm}, 8'h00);
  endtask

  task automatic testClkBurst();
    beginTxn();
    sendByte(8'hBE);
    for (int i = 0; i < 7; i++) sendByte(8'h10 + 8'(i));
    sendByte(8'h00);
    endTxn();
    beginTxn();
    sendByte(8'hBF);
    check("R11 R4 burst byte 0", rdData, 8'h10);
    for (int i = 1; i < 7; i++) begin
      sendByte(8'h00);
      check("R4 burst clock byte", rdData, 8'h10 + 8'(i));
    end
    sendByte(8'h00); check("R4 burst control byte", rdData, 8'h00);
    sendByte(8'h00); check("R8 clock burst past end", rdData, 8'h00);
    endTxn();
  endtask

  task automatic testClkPartial();
    logic [7:0] v;
    beginTxn();
    sendByte(8'hBE);
    for (int i = 0; i < 5; i++) sendByte(8'hA0 + 8'(i));
    endTxn();
    readReg(8'h81, v); check("R5 partial burst seconds", v, 8'h10);
    readReg(8'h89, v); check("R5 partial burst month", v, 8'h14);
  endtask

  task automatic testClkWp();
    logic [7:0] v;
    writeReg(8'h8E, 8'h80);
    beginTxn();
    sendByte(8'hBE);
    for (int i = 0; i < 7; i++) sendByte(8'h30 + 8'(i));
    sendByte(8'h00);
    endTxn();
    readReg(8'h81, v); check("R6 protected burst seconds", v, 8'h10);
    readReg(8'h8D, v); check("R6 protected burst year", v, 8'h16);
    readReg(8'h8F, v); check("R6 protected burst control", v, 8'h80);
    writeReg(8'h8E, 8'h00);
  endtask

  task automatic testRamBurst();
    logic [7:0] v;
    beginTxn();
    sendByte(8'hFE);
    for (int i = 0; i < 3; i++) begin
      sendByte(8'hE0 + 8'(i));
      ramExp[i] = 8'hE0 + 8'(i);
    end
    endTxn();
    readReg(8'hC1, v); check("R7 partial ram burst byte0", v, 8'hE0);
    readReg(8'hC5, v); check("R7 partial ram burst byte2", v, 8'hE2);
    readReg(8'hC7, v); check("R7 byte after partial burst", v, 8'h00);
    beginTxn();
    sendByte(8'hFF);
    check("R7 ram burst read 0", rdData, ramExp[0]);
    for (int i = 1; i < 31; i++) begin
      sendByte(8'h00);
      check("R7 ram burst read", rdData, ramExp[i]);
    end
    sendByte(8'h00); check("R8 ram burst past end", rdData, 8'h00);
    endTxn();
  endtask

  initial begin
    for (int i = 0; i < 31; i++) ramExp[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWpBlocks();
    testControl();
    testSingle();
    testSingleExtra();
    testHours();
    testClkBurst();
    testClkPartial();
    testClkWp();
    testRamBurst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule